// File: doc/BRIEF.md
# Variable-Page-Size Address Translation Buffer

This block translates a 32-bit effective address into a physical address through a small, fully associative table of page mappings. Each slot holds a valid flag, a virtual page tag, a 3-bit page-size code, a real page number and three permission flags. The permission flags are write-allowed, execute-allowed and user-accessible. The page-size code of each slot sets how many upper address bits take part in the tag compare. It also sets how many upper real-page-number bits replace those address bits in the result. The remaining low bits pass through unchanged from the effective address as the page offset.

A request names the effective address, the access kind and whether the requester runs at user level. One cycle later the block returns one of four outcomes: a translated address, a miss, a protection fault, or, with translation turned off, the effective address passed through untouched. A build parameter widens the real page number so the result becomes a 40-bit physical address. A simple write port loads or invalidates one slot per cycle.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every slot is invalid and `rsp_vld` is low, so the first lookup after reset reports a miss.
- R2: `rsp_vld`, `rsp_hit`, `rsp_miss`, `rsp_prot` and `rsp_pa` are registered. `rsp_vld` is high exactly in the cycle after a cycle with `req_vld` high.
- R3: With `xlat_en` low, the response carries the effective address zero-extended in `rsp_pa`, with `rsp_hit`, `rsp_miss` and `rsp_prot` all low, whatever the slots hold and whatever the access kind.
- R4: With `xlat_en` high and no valid slot matching, the response has `rsp_miss` high, `rsp_hit` low, `rsp_prot` low and `rsp_pa` zero.
- R5: A slot with size code s (0..7 selecting 1 kB, 4 kB, 16 kB, 64 kB, 256 kB, 1 MB, 4 MB or 16 MB) matches when effective-address bits [31:10+2s] equal tag bits [21:2s]. The tag holds effective-address bits [31:10], and lower tag bits are ignored.
- R6: On a hit, `rsp_pa` bits [PA_W-1:10+2s] are real-page-number bits [RPN_W-1:2s], and bits [10+2s-1:0] are the matching effective-address bits. Real-page-number bits below 2s have no effect.
- R7: With `EXT_PA` = 0 the real page number is 22 bits and `rsp_pa` is 32 bits. With `EXT_PA` = 1 they are 30 and 40 bits, and the same placement rule applies.
- R8: A matching slot denies the request in three cases: `req_kind` is write (2'b01) and the write flag is clear, `req_kind` is execute (2'b10) and the execute flag is clear, or `req_user` is high and the user flag is clear. A denial reports `rsp_prot` and `rsp_hit` high, `rsp_miss` low and `rsp_pa` zero. Kinds 2'b00 and 2'b11 are reads and are never denied by the write or execute flags.
- R9: When several valid slots match, the lowest-numbered one supplies the result.
- R10: A write with `wr_en` high stores tag, size, page number and flags into slot `wr_idx`, and sets its valid flag to `wr_valid`. A lookup issued in the same cycle as a write sees the slot contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable; low selects pass-through mode |
| req_vld | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address |
| req_kind | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| req_user | input | 1 | Requester runs at user level |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | IDX_W (3) | Slot number to write |
| wr_valid | input | 1 | Valid flag written into the slot |
| wr_tag | input | 22 | Effective-address bits [31:10] of the page |
| wr_size | input | 3 | Page-size code |
| wr_rpn | input | RPN_W (22 or 30) | Real page number |
| wr_wperm | input | 1 | Write allowed |
| wr_xperm | input | 1 | Execute allowed |
| wr_uperm | input | 1 | User level allowed |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | A slot matched |
| rsp_pa | output | PA_W (32 or 40) | Physical address |
| rsp_miss | output | 1 | No valid slot matched |
| rsp_prot | output | 1 | Matched slot denies the access |

## Verification
The bench builds two copies side by side from the same stimulus: one with `EXT_PA` = 0 and one with `EXT_PA` = 1, both with eight slots. Each copy is loaded with its own page numbers. This puts both placement widths of the page number under one set of lookups, so a slip in how many page-number bits are kept shows in one copy or the other. Eight slots leave room for a 1 kB page nested inside a 16 MB page, which exercises lowest-slot priority. They also leave room for an invalidated slot and a slot written in the same cycle as a lookup.

// File: rtl/tlb_xlate_pkg.sv
package tlb_xlate_pkg;

  localparam int EA_W        = 32;
  localparam int PAGE_MIN_LG = 10;
  localparam int TAG_W       = EA_W - PAGE_MIN_LG;
  localparam int SIZE_W      = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [SIZE_W-1:0] size;
    logic              wperm;
    logic              xperm;
    logic              uperm;
  } slot_meta_t;

  // Tag bits that take part in the compare for a given size code:
  // each code step quadruples the page, dropping two more low tag bits.
  function automatic logic [TAG_W-1:0] cmp_mask(input logic [SIZE_W-1:0] sz);
    logic [TAG_W-1:0] m;
    for (int i = 0; i < TAG_W; i++) begin
      m[i] = (i >= 2 * int'(sz));
    end
    return m;
  endfunction

endpackage

// File: rtl/tlb_slot_store.sv
module tlb_slot_store
  import tlb_xlate_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int RPN_W   = 22,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic                            wr_valid,
  input  slot_meta_t                      wr_meta,
  input  logic [RPN_W-1:0]                wr_rpn,
  output logic [N_SLOTS-1:0]              slot_vld,
  output slot_meta_t [N_SLOTS-1:0]        slot_meta,
  output logic [N_SLOTS-1:0][RPN_W-1:0]   slot_rpn
);

  logic [N_SLOTS-1:0]            vld_d, vld_q;
  slot_meta_t [N_SLOTS-1:0]      meta_q;
  logic [N_SLOTS-1:0][RPN_W-1:0] rpn_q;

  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[wr_idx] = wr_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Payload carries no reset: it is only read while the valid flag is set.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      meta_q[wr_idx] <= wr_meta;
      rpn_q[wr_idx]  <= wr_rpn;
    end
  end

  assign slot_vld  = vld_q;
  assign slot_meta = meta_q;
  assign slot_rpn  = rpn_q;

  // R10
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (slot_vld[$past(wr_idx)] == $past(wr_valid)));

  // R1
  rst_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (slot_vld == '0));

endmodule

// File: rtl/tlb_slot_match.sv
module tlb_slot_match
  import tlb_xlate_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter int RPN_W   = 22,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [TAG_W-1:0]                ea_tag,
  input  logic [N_SLOTS-1:0]              slot_vld,
  input  slot_meta_t [N_SLOTS-1:0]        slot_meta,
  input  logic [N_SLOTS-1:0][RPN_W-1:0]   slot_rpn,
  output logic                            any_hit,
  output slot_meta_t                      sel_meta,
  output logic [RPN_W-1:0]                sel_rpn
);

  logic [N_SLOTS-1:0] hit_vec;
  logic [N_SLOTS-1:0] sel_oh;
  logic [IDX_W-1:0]   sel_idx;

  for (genvar e = 0; e < N_SLOTS; e++) begin : g_cmp
    logic [TAG_W-1:0] diff;
    assign diff       = (ea_tag ^ slot_meta[e].tag) & cmp_mask(slot_meta[e].size);
    assign hit_vec[e] = slot_vld[e] && (diff == '0);
  end

  // Lowest-numbered matching slot wins.
  assign sel_oh = hit_vec & (~hit_vec + N_SLOTS'(1));

  always_comb begin
    sel_idx = '0;
    for (int e = N_SLOTS - 1; e >= 0; e--) begin
      if (hit_vec[e]) begin
        sel_idx = IDX_W'(e);
      end
    end
  end

  assign any_hit  = |hit_vec;
  assign sel_meta = slot_meta[sel_idx];
  assign sel_rpn  = slot_rpn[sel_idx];

  // R9
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  // R9
  sel_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> (sel_oh[sel_idx] && hit_vec[sel_idx]));

endmodule

// File: rtl/tlb_resp_stage.sv
module tlb_resp_stage
  import tlb_xlate_pkg::*;
#(
  parameter int PA_W  = 32,
  parameter int RPN_W = PA_W - PAGE_MIN_LG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  input  logic              xlat_en,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic              any_hit,
  input  slot_meta_t        sel_meta,
  input  logic [RPN_W-1:0]  sel_rpn,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_miss,
  output logic              rsp_prot
);

  logic            deny;
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] xl_pa;
  logic            hit_d, miss_d, prot_d;
  logic [PA_W-1:0] pa_d;
  int              off_lg;

  always_comb begin
    deny = ((req_kind == ACC_WRITE) && !sel_meta.wperm) ||
           ((req_kind == ACC_EXEC)  && !sel_meta.xperm) ||
           (req_user && !sel_meta.uperm);
    off_lg   = PAGE_MIN_LG + 2 * int'(sel_meta.size);
    off_mask = (PA_W'(1) << off_lg) - PA_W'(1);
    xl_pa    = ({sel_rpn, {PAGE_MIN_LG{1'b0}}} & ~off_mask) |
               (PA_W'(req_ea) & off_mask);
  end

  always_comb begin
    hit_d  = 1'b0;
    miss_d = 1'b0;
    prot_d = 1'b0;
    pa_d   = '0;
    if (!xlat_en) begin
      pa_d = PA_W'(req_ea);
    end else if (!any_hit) begin
      miss_d = 1'b1;
    end else if (deny) begin
      hit_d  = 1'b1;
      prot_d = 1'b1;
    end else begin
      hit_d = 1'b1;
      pa_d  = xl_pa;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit  <= 1'b0;
      rsp_miss <= 1'b0;
      rsp_prot <= 1'b0;
      rsp_pa   <= '0;
    end else if (req_vld) begin
      rsp_hit  <= hit_d;
      rsp_miss <= miss_d;
      rsp_prot <= prot_d;
      rsp_pa   <= pa_d;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> !rsp_vld);

  // R3
  real_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !xlat_en) |=>
      (rsp_pa == PA_W'($past(req_ea)) && !rsp_hit && !rsp_miss && !rsp_prot));

  // R4
  miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && !rsp_prot && rsp_pa == '0));

  // R8
  prot_nopa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_prot |-> (rsp_hit && !rsp_miss && rsp_pa == '0));

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_xlate_pkg::*;
#(
  parameter int N_SLOTS = 8,
  parameter bit EXT_PA  = 1'b0,
  localparam int PA_W   = EXT_PA ? 40 : 32,
  localparam int RPN_W  = PA_W - PAGE_MIN_LG,
  localparam int IDX_W  = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlat_en,
  input  logic              req_vld,
  input  logic [EA_W-1:0]   req_ea,
  input  logic [1:0]        req_kind,
  input  logic              req_user,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic [RPN_W-1:0]  wr_rpn,
  input  logic              wr_wperm,
  input  logic              wr_xperm,
  input  logic              wr_uperm,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_miss,
  output logic              rsp_prot
);

  slot_meta_t                    wr_meta;
  logic [N_SLOTS-1:0]            slot_vld;
  slot_meta_t [N_SLOTS-1:0]      slot_meta;
  logic [N_SLOTS-1:0][RPN_W-1:0] slot_rpn;
  logic                          any_hit;
  slot_meta_t                    sel_meta;
  logic [RPN_W-1:0]              sel_rpn;

  always_comb begin
    wr_meta.tag   = wr_tag;
    wr_meta.size  = wr_size;
    wr_meta.wperm = wr_wperm;
    wr_meta.xperm = wr_xperm;
    wr_meta.uperm = wr_uperm;
  end

  tlb_slot_store #(
    .N_SLOTS (N_SLOTS),
    .RPN_W   (RPN_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_valid  (wr_valid),
    .wr_meta   (wr_meta),
    .wr_rpn    (wr_rpn),
    .slot_vld  (slot_vld),
    .slot_meta (slot_meta),
    .slot_rpn  (slot_rpn)
  );

  tlb_slot_match #(
    .N_SLOTS (N_SLOTS),
    .RPN_W   (RPN_W)
  ) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .ea_tag    (req_ea[EA_W-1:PAGE_MIN_LG]),
    .slot_vld  (slot_vld),
    .slot_meta (slot_meta),
    .slot_rpn  (slot_rpn),
    .any_hit   (any_hit),
    .sel_meta  (sel_meta),
    .sel_rpn   (sel_rpn)
  );

  tlb_resp_stage #(
    .PA_W  (PA_W),
    .RPN_W (RPN_W)
  ) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .xlat_en  (xlat_en),
    .req_ea   (req_ea),
    .req_kind (req_kind),
    .req_user (req_user),
    .any_hit  (any_hit),
    .sel_meta (sel_meta),
    .sel_rpn  (sel_rpn),
    .rsp_vld  (rsp_vld),
    .rsp_hit  (rsp_hit),
    .rsp_pa   (rsp_pa),
    .rsp_miss (rsp_miss),
    .rsp_prot (rsp_prot)
  );

endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;

  localparam int N_VEC = 18;

  // outcome codes: 0 pass-through, 1 hit, 2 miss, 3 protection fault
  typedef struct packed {
    logic [31:0] ea;
    logic [1:0]  kind;
    logic        user;
    logic        xl;
    logic [1:0]  outc;
    logic [2:0]  slot;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{32'h0000_0455, 2'b00, 1'b1, 1'b1, 2'd1, 3'd0, 4'd6},  // R6 1 kB page
    '{32'h0000_0455, 2'b01, 1'b0, 1'b1, 2'd1, 3'd0, 4'd8},  // R8 write allowed
    '{32'h0000_0455, 2'b10, 1'b0, 1'b1, 2'd3, 3'd0, 4'd8},  // R8 exec denied
    '{32'h0000_0855, 2'b00, 1'b0, 1'b1, 2'd2, 3'd0, 4'd5},  // R5 neighbour 1 kB
    '{32'h1007_FFFC, 2'b00, 1'b0, 1'b1, 2'd1, 3'd1, 4'd5},  // R5 top of 256 kB
    '{32'h1008_0000, 2'b00, 1'b0, 1'b1, 2'd2, 3'd1, 4'd4},  // R4 past 256 kB
    '{32'h1004_0010, 2'b01, 1'b0, 1'b1, 2'd3, 3'd1, 4'd8},  // R8 write denied
    '{32'h1004_0010, 2'b00, 1'b1, 1'b1, 2'd3, 3'd1, 4'd8},  // R8 user denied
    '{32'h1004_0010, 2'b10, 1'b0, 1'b1, 2'd1, 3'd1, 4'd6},  // R6 256 kB exec
    '{32'h1005_1234, 2'b11, 1'b0, 1'b1, 2'd1, 3'd1, 4'd8},  // R8 kind 11 is read
    '{32'hA0FF_0000, 2'b10, 1'b1, 1'b1, 2'd1, 3'd2, 4'd6},  // R6 16 MB
    '{32'hA000_1234, 2'b00, 1'b0, 1'b1, 2'd1, 3'd2, 4'd9},  // R9 nested pages
    '{32'h3000_0000, 2'b00, 1'b0, 1'b1, 2'd2, 3'd5, 4'd10}, // R10 invalidated
    '{32'h1234_5678, 2'b01, 1'b1, 1'b0, 2'd0, 3'd0, 4'd3},  // R3 real mode
    '{32'h0000_0455, 2'b10, 1'b1, 1'b0, 2'd0, 3'd0, 4'd3},  // R3 no prot
    '{32'h0000_7FFF, 2'b10, 1'b1, 1'b1, 2'd1, 3'd3, 4'd5},  // R5 16 kB top
    '{32'h0000_8000, 2'b00, 1'b0, 1'b1, 2'd2, 3'd3, 4'd4},  // R4 past 16 kB
    '{32'hA100_0000, 2'b00, 1'b0, 1'b1, 2'd2, 3'd2, 4'd7}   // R7 miss both widths
  };

  logic        clk;
  logic        rst_n;
  logic        xlat_en;
  logic        req_vld;
  logic [31:0] req_ea;
  logic [1:0]  req_kind;
  logic        req_user;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic        wr_valid;
  logic [21:0] wr_tag;
  logic [2:0]  wr_size;
  logic [21:0] wr_rpn_n;
  logic [29:0] wr_rpn_x;
  logic        wr_wperm, wr_xperm, wr_uperm;

  logic        vld_n, hit_n, miss_n, prot_n;
  logic [31:0] pa_n;
  logic        vld_x, hit_x, miss_x, prot_x;
  logic [39:0] pa_x;

  logic [21:0] sh_rpn_n [8];
  logic [29:0] sh_rpn_x [8];
  logic [2:0]  sh_sz    [8];

  int n_chk;
  int n_bad;
  int cyc;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  tlb_xlate #(.N_SLOTS(8), .EXT_PA(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_vld(req_vld),
    .req_ea(req_ea), .req_kind(req_kind), .req_user(req_user),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_size(wr_size), .wr_rpn(wr_rpn_n), .wr_wperm(wr_wperm),
    .wr_xperm(wr_xperm), .wr_uperm(wr_uperm),
    .rsp_vld(vld_n), .rsp_hit(hit_n), .rsp_pa(pa_n),
    .rsp_miss(miss_n), .rsp_prot(prot_n)
  );

  tlb_xlate #(.N_SLOTS(8), .EXT_PA(1'b1)) dut_ext_i (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .req_vld(req_vld),
    .req_ea(req_ea), .req_kind(req_kind), .req_user(req_user),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_tag(wr_tag),
    .wr_size(wr_size), .wr_rpn(wr_rpn_x), .wr_wperm(wr_wperm),
    .wr_xperm(wr_xperm), .wr_uperm(wr_uperm),
    .rsp_vld(vld_x), .rsp_hit(hit_x), .rsp_pa(pa_x),
    .rsp_miss(miss_x), .rsp_prot(prot_x)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
        finish_run();
      end
    end
  end

  // Page placement rule from R6: upper page-number bits over the offset.
  function automatic logic [39:0] model_pa(input logic [29:0] rpn,
                                           input logic [2:0] sz,
                                           input logic [31:0] ea);
    int          off;
    logic [39:0] m;
    off = 10 + 2 * int'(sz);
    m   = (40'd1 << off) - 40'd1;
    return ((40'(rpn) << 10) & ~m) | (40'(ea) & m);
  endfunction

  task automatic check(input string tag, input logic [3:0] exp_flags,
                       input logic [3:0] act_flags,
                       input logic [39:0] exp_pa, input logic [39:0] act_pa);
    n_chk++;
    if (exp_flags !== act_flags || exp_pa !== act_pa) begin
      n_bad++;
      $display("FAIL %s: actual vld/hit/miss/prot=%b pa=%h expected %b pa=%h",
               tag, act_flags, act_pa, exp_flags, exp_pa);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic v, input logic [31:0] base,
                      input logic [2:0] sz, input logic [21:0] rn,
                      input logic [29:0] rx, input logic w, input logic x,
                      input logic u);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_tag = base[31:10];
    wr_size = sz; wr_rpn_n = rn; wr_rpn_x = rx;
    wr_wperm = w; wr_xperm = x; wr_uperm = u;
    sh_rpn_n[idx] = rn; sh_rpn_x[idx] = rx; sh_sz[idx] = sz;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [1:0] kind,
                        input logic user, input logic xl);
    @(negedge clk);
    req_vld = 1'b1; req_ea = ea; req_kind = kind; req_user = user; xlat_en = xl;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  task automatic expect_rsp(input string tag, input logic [1:0] outc,
                            input logic [2:0] slot, input logic [31:0] ea);
    logic [3:0]  f;
    logic [39:0] en, ex;
    case (outc)
      2'd0: begin f = 4'b1000; en = 40'(ea); ex = 40'(ea); end
      2'd1: begin
        f  = 4'b1100;
        en = model_pa(30'(sh_rpn_n[slot]), sh_sz[slot], ea);
        ex = model_pa(sh_rpn_x[slot], sh_sz[slot], ea);
      end
      2'd2: begin f = 4'b1010; en = '0; ex = '0; end
      default: begin f = 4'b1101; en = '0; ex = '0; end
    endcase
    check({tag, " narrow"}, f, {vld_n, hit_n, miss_n, prot_n}, en, 40'(pa_n));
    check({tag, " wide R7"}, f, {vld_x, hit_x, miss_x, prot_x}, ex, pa_x);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; xlat_en = 1'b1; req_vld = 1'b0; req_ea = '0;
    req_kind = '0; req_user = 1'b0; wr_en = 1'b0; wr_idx = '0;
    wr_valid = 1'b0; wr_tag = '0; wr_size = '0; wr_rpn_n = '0; wr_rpn_x = '0;
    wr_wperm = 1'b0; wr_xperm = 1'b0; wr_uperm = 1'b0;
    for (int i = 0; i < 8; i++) begin
      sh_rpn_n[i] = '0; sh_rpn_x[i] = '0; sh_sz[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset outputs", 4'b0000, {vld_n, hit_n, miss_n, prot_n}, '0, 40'(pa_n));
    check("R1 reset outputs wide", 4'b0000, {vld_x, hit_x, miss_x, prot_x}, '0, pa_x);
    lookup(32'h0000_0455, 2'b00, 1'b0, 1'b1);
    expect_rsp("R1 empty table", 2'd2, 3'd0, 32'h0000_0455);

    // slot contents; page-number low bits deliberately nonzero (R6)
    load(3'd0, 1'b1, 32'h0000_0400, 3'd0, 22'h2AAAAA, 30'h2AAAAAAA, 1'b1, 1'b0, 1'b1);
    load(3'd1, 1'b1, 32'h1004_0000, 3'd4, 22'h2C0A5B, 30'h12345678, 1'b0, 1'b1, 1'b0);
    load(3'd2, 1'b1, 32'hA000_0000, 3'd7, 22'h1F0F0F, 30'h3C3C3C3C, 1'b1, 1'b1, 1'b1);
    load(3'd3, 1'b1, 32'h0000_4000, 3'd2, 22'h000155, 30'h00ABCDE0, 1'b1, 1'b1, 1'b1);
    load(3'd4, 1'b1, 32'hA000_1000, 3'd0, 22'h3FFFFF, 30'h3FFFFFFF, 1'b1, 1'b1, 1'b1);
    load(3'd5, 1'b1, 32'h3000_0000, 3'd3, 22'h001111, 30'h00222222, 1'b1, 1'b1, 1'b1);
    load(3'd5, 1'b0, 32'h3000_0000, 3'd3, 22'h001111, 30'h00222222, 1'b1, 1'b1, 1'b1);

    for (int v = 0; v < N_VEC; v++) begin
      lookup(VECS[v].ea, VECS[v].kind, VECS[v].user, VECS[v].xl);
      expect_rsp($sformatf("R%0d vec%0d", VECS[v].req, v), VECS[v].outc,
                 VECS[v].slot, VECS[v].ea);
    end

    // R2 no response in a cycle after no request
    @(negedge clk);
    check("R2 idle", 4'b0000, {vld_n, 3'b000}, '0, '0);
    check("R2 idle wide", 4'b0000, {vld_x, 3'b000}, '0, '0);

    // R10 write and lookup in the same cycle: old contents
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd6; wr_valid = 1'b1; wr_tag = 22'h140000;
    wr_size = 3'd1; wr_rpn_n = 22'h0ABCDE; wr_rpn_x = 30'h0ABCDEF0;
    wr_wperm = 1'b1; wr_xperm = 1'b1; wr_uperm = 1'b1;
    sh_rpn_n[6] = 22'h0ABCDE; sh_rpn_x[6] = 30'h0ABCDEF0; sh_sz[6] = 3'd1;
    req_vld = 1'b1; req_ea = 32'h5000_0ABC; req_kind = 2'b00; req_user = 1'b0;
    xlat_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; req_vld = 1'b0;
    expect_rsp("R10 same-cycle write", 2'd2, 3'd6, 32'h5000_0ABC);
    lookup(32'h5000_0ABC, 2'b01, 1'b1, 1'b1);
    expect_rsp("R10 after write", 2'd1, 3'd6, 32'h5000_0ABC);

    finish_run();
  end

endmodule